// File: doc/BRIEF.md
# Peripheral Bus Write Latch

This block sits between a CPU load/store port and a slow cartridge-style peripheral bus. A write that the bus accepts is posted: the block captures it in a 32-bit holding register, forwards it to the bus, and raises an I/O-busy flag for a fixed drain time while the slow bus finishes. During the drain, further writes are thrown away, except writes to one configurable debug address, which still reach the bus. Those debug writes leave the holding register and the drain timer alone.

A read that arrives during a drain never reaches the bus. It is answered from the holding register, formatted for the access size. It ends the drain at once. In the same cycle the block emits a one-cycle stall pulse that carries the number of drain cycles that were still left. An external cycle accumulator adds this number to its count, so the CPU pays for the wait it skipped. When no drain is active, reads pass straight to the bus path.

Access sizes use the encoding 0 = byte, 1 = halfword, 2 = word, 3 = doubleword.

Top module: `pbus_wlatch`

## Requirements
- R1: After reset, io_busy is low and stall_valid is low. A read then goes to the bus path (bus_valid high, latch_hit low). The holding register resets to zero.
- R2: A write accepted while io_busy is low is forwarded on the bus in the same cycle. From the next cycle, io_busy stays high for exactly DRAIN_CYCLES cycles (default 100) and then falls.
- R3: A write to any address other than DEBUG_ADDR that arrives while io_busy is high is not forwarded (bus_valid low). It changes neither the holding register nor the remaining drain time.
- R4: A write to DEBUG_ADDR that arrives while io_busy is high is forwarded on the bus. It changes neither the holding register nor the remaining drain time.
- R5: An accepted byte write (size 0) places wdata[7:0] at bits 31:24 of the holding register when addr[0] is 0, and at bits 23:16 when addr[0] is 1. All other bits become zero.
- R6: An accepted halfword write (size 1) stores {wdata[15:0], 16'h0}. A word write (size 2) stores wdata[31:0]. A doubleword write (size 3) stores wdata[63:32].
- R7: A read while io_busy is high is not forwarded, and latch_hit is high. latch_rdata is the holding register formatted by size: size 0 gives bits 31:24, size 1 gives bits 31:16, size 2 gives all 32 bits, each zero-extended to 64 bits. Size 3 gives {register, 32'h0}.
- R8: A read while io_busy is high gives a stall_valid pulse of exactly one cycle. Its stall_cycles equals DRAIN_CYCLES + 1 − k, where k is the number of cycles since the write was accepted (k = 1 in the first busy cycle). io_busy is low from the next cycle.
- R9: A read while io_busy is low is forwarded on the bus with latch_hit low and stall_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data, right-aligned for the size |
| bus_valid | output | 1 | Access forwarded to the peripheral bus |
| bus_write | output | 1 | Forwarded access direction |
| bus_size | output | 2 | Forwarded access size |
| bus_addr | output | ADDR_W | Forwarded address |
| bus_wdata | output | 64 | Forwarded write data |
| latch_hit | output | 1 | Read answered from the holding register |
| latch_rdata | output | 64 | Formatted holding-register data |
| stall_valid | output | 1 | One-cycle stall charge pulse |
| stall_cycles | output | STALL_W | Cycles to charge to the CPU |
| io_busy | output | 1 | Drain in progress |

## Verification
The hardest case to reach is a read that lands at an exact point of a drain. The expected stall depends on that cycle offset. At the last busy cycle, the read races the natural end of the drain. The bench posts a write and then issues a read after every delay from 1 to DRAIN_CYCLES idle cycles. It also issues one read one cycle after the drain ends, so the whole remaining-time range and both edges are covered. Drops and debug-address exemptions are checked in mid-drain, followed by a read that shows the register and the remaining time did not change.

// File: rtl/pbus_wlatch_pkg.sv
package pbus_wlatch_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int unsigned HOLD_W = 32;
    localparam int unsigned DATA_W = 64;
endpackage

// File: rtl/pbus_drain_timer.sv
module pbus_drain_timer #(
    parameter int unsigned DRAIN_CYCLES = 100,
    localparam int unsigned CNT_W = $clog2(DRAIN_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    output logic             busy,
    output logic [CNT_W-1:0] remain
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(DRAIN_CYCLES);
        end else if (cancel) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign remain = st_q.cnt;

    // R2: a start loads the full drain time
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && remain == CNT_W'(DRAIN_CYCLES)));
    // R2: while busy the count stays within 1..DRAIN_CYCLES
    p_remain_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain >= CNT_W'(1) && remain <= CNT_W'(DRAIN_CYCLES)));
    // R2: the count falls by one per idle busy cycle
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !cancel && remain > CNT_W'(1)) |=> (busy && remain == $past(remain) - CNT_W'(1)));
    // R8: a cancel ends the drain
    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !start) |=> !busy);
endmodule

// File: rtl/pbus_latch_pack.sv
module pbus_latch_pack
    import pbus_wlatch_pkg::*;
(
    input  acc_size_e          size,
    input  logic               addr_lsb,
    input  logic [DATA_W-1:0]  wdata,
    output logic [HOLD_W-1:0]  hold
);
    always_comb begin
        unique case (size)
            SZ_BYTE:  hold = addr_lsb ? {8'h00, wdata[7:0], 16'h0000}
                                      : {wdata[7:0], 24'h000000};
            SZ_HALF:  hold = {wdata[15:0], 16'h0000};
            SZ_WORD:  hold = wdata[31:0];
            default:  hold = wdata[63:32];
        endcase
    end
endmodule

// File: rtl/pbus_latch_unpack.sv
module pbus_latch_unpack
    import pbus_wlatch_pkg::*;
(
    input  acc_size_e          size,
    input  logic [HOLD_W-1:0]  hold,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        unique case (size)
            SZ_BYTE:  rdata = {56'h0, hold[31:24]};
            SZ_HALF:  rdata = {48'h0, hold[31:16]};
            SZ_WORD:  rdata = {32'h0, hold};
            default:  rdata = {hold, 32'h0};
        endcase
    end
endmodule

// File: rtl/pbus_wlatch.sv
module pbus_wlatch
    import pbus_wlatch_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned DRAIN_CYCLES = 100,
    parameter int unsigned STALL_W      = 8,
    parameter logic [ADDR_W-1:0] DEBUG_ADDR = ADDR_W'(32'h0500_0020)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [63:0]        req_wdata,
    output logic               bus_valid,
    output logic               bus_write,
    output logic [1:0]         bus_size,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [63:0]        bus_wdata,
    output logic               latch_hit,
    output logic [63:0]        latch_rdata,
    output logic               stall_valid,
    output logic [STALL_W-1:0] stall_cycles,
    output logic               io_busy
);
    localparam int unsigned CNT_W = $clog2(DRAIN_CYCLES + 1);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
    } lat_t;

    lat_t              st_d, st_q;
    logic              busy;
    logic [CNT_W-1:0]  remain;
    logic              wr_req, rd_req, is_dbg;
    logic              accept_wr, drop_wr, stale_rd;
    logic [HOLD_W-1:0] packed_hold;
    acc_size_e         size_e;

    assign size_e    = acc_size_e'(req_size);
    assign wr_req    = req_valid &&  req_write;
    assign rd_req    = req_valid && !req_write;
    assign is_dbg    = (req_addr == DEBUG_ADDR);
    assign accept_wr = wr_req && !busy;
    assign drop_wr   = wr_req && busy && !is_dbg;
    assign stale_rd  = rd_req && busy;

    pbus_latch_pack i_pack (
        .size     (size_e),
        .addr_lsb (req_addr[0]),
        .wdata    (req_wdata),
        .hold     (packed_hold)
    );

    pbus_latch_unpack i_unpack (
        .size  (size_e),
        .hold  (st_q.hold),
        .rdata (latch_rdata)
    );

    pbus_drain_timer #(.DRAIN_CYCLES(DRAIN_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept_wr),
        .cancel (stale_rd),
        .busy   (busy),
        .remain (remain)
    );

    always_comb begin
        st_d = st_q;
        if (accept_wr) st_d.hold = packed_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_valid    = req_valid && !drop_wr && !stale_rd;
        bus_write    = req_write;
        bus_size     = req_size;
        bus_addr     = req_addr;
        bus_wdata    = req_wdata;
        latch_hit    = stale_rd;
        stall_valid  = stale_rd;
        stall_cycles = '0;
        if (stale_rd) stall_cycles[CNT_W-1:0] = remain;
    end

    assign io_busy = busy;

    // R3: a dropped write leaves the holding register untouched
    p_drop_keeps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_wr |=> (st_q.hold == $past(st_q.hold)));
    // R4: a debug write during a drain leaves the holding register untouched
    p_dbg_keeps_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && busy && is_dbg) |=> (st_q.hold == $past(st_q.hold)));
    // R8: the stall pulse lasts one cycle
    p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid |=> !stall_valid);
    // R8: the stall charge lies inside the drain window
    p_stall_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid |-> (stall_cycles >= STALL_W'(1) && stall_cycles <= STALL_W'(DRAIN_CYCLES)));
    // R7: a stale read never reaches the bus
    p_stale_not_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_hit |-> !bus_valid);
endmodule

// File: tb/test_pbus_wlatch.sv
module test_pbus_wlatch;
    localparam int unsigned DRAIN = 100;
    localparam logic [31:0] DBG   = 32'h0500_0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        bus_valid, bus_write, latch_hit, stall_valid, io_busy;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata, latch_rdata;
    logic [7:0]  stall_cycles;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pbus_wlatch i_pbus_wlatch (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .latch_hit(latch_hit), .latch_rdata(latch_rdata),
        .stall_valid(stall_valid), .stall_cycles(stall_cycles), .io_busy(io_busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_hold(input int sz, input bit lsb, input logic [63:0] d);
        case (sz)
            0: return lsb ? {8'h0, d[7:0], 16'h0} : {d[7:0], 24'h0};
            1: return {d[15:0], 16'h0};
            2: return d[31:0];
            default: return d[63:32];
        endcase
    endfunction

    function automatic logic [63:0] exp_read(input int sz, input logic [31:0] h);
        case (sz)
            0: return {56'h0, h[31:24]};
            1: return {48'h0, h[31:16]};
            2: return {32'h0, h};
            default: return {h, 32'h0};
        endcase
    endfunction

    // drive at negedge, settle, sample before the next posedge
    task automatic drive(input bit v, input bit w, input int sz, input logic [31:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = v; req_write = w; req_size = 2'(sz); req_addr = a; req_wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 0, 32'h0, 64'h0);
    endtask

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] h;
        int busy_cnt;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle();
        chk("R1 io_busy", io_busy, 0);
        chk("R1 stall_valid", stall_valid, 0);
        drive(1, 0, 2, 32'h1000_0000, 0);
        chk("R1 read forwarded", bus_valid, 1);
        chk("R1 latch_hit", latch_hit, 0);
        // R9 idle read
        chk("R9 no stall", stall_valid, 0);

        // R2 drain length
        drive(1, 1, 2, 32'h1000_0004, 64'h0000_0000_1234_5678);
        chk("R2 write forwarded", bus_valid, 1);
        busy_cnt = 0;
        for (int i = 0; i < DRAIN + 5; i++) begin
            idle();
            if (io_busy) busy_cnt++;
        end
        chk("R2 busy cycles", 64'(busy_cnt), 64'(DRAIN));
        chk("R2 busy cleared", io_busy, 0);

        // R5 R6 R7 alignment sweep over write size, lsb, read size
        for (int ws = 0; ws < 4; ws++) begin
            for (int lsb = 0; lsb < 2; lsb++) begin
                for (int rs = 0; rs < 4; rs++) begin
                    logic [63:0] d;
                    d = {32'hA1B2_C3D4, 8'(ws * 16 + lsb * 4 + rs), 24'h5E6F70};
                    h = exp_hold(ws, lsb[0], d);
                    drive(1, 1, ws, 32'h1000_0010 | 32'(lsb), d);
                    drive(1, 0, rs, 32'h1000_0020, 0);
                    if (ws == 0) chk("R5 byte placement", latch_rdata, exp_read(rs, h));
                    else         chk("R6 size placement", latch_rdata, exp_read(rs, h));
                    chk("R7 latch_hit", latch_hit, 1);
                    chk("R7 not forwarded", bus_valid, 0);
                    idle();
                    chk("R8 busy cleared after read", io_busy, 0);
                end
            end
        end

        // R8 stall remaining-time sweep
        for (int k = 1; k <= DRAIN; k++) begin
            drive(1, 1, 2, 32'h1000_0030, 64'(k));
            for (int j = 1; j < k; j++) idle();
            drive(1, 0, 2, 32'h1000_0030, 0);
            chk("R8 stall_valid", stall_valid, 1);
            chk("R8 stall_cycles", 64'(stall_cycles), 64'(DRAIN + 1 - k));
            idle();
            chk("R8 one-cycle pulse", stall_valid, 0);
            chk("R8 busy low", io_busy, 0);
        end
        // R9 read one cycle after natural end
        drive(1, 1, 2, 32'h1000_0030, 64'h77);
        for (int j = 1; j <= DRAIN; j++) idle();
        drive(1, 0, 2, 32'h1000_0030, 0);
        chk("R9 forwarded after drain", bus_valid, 1);
        chk("R9 no stall after drain", stall_valid, 0);
        chk("R9 no latch_hit", latch_hit, 0);

        // R3 dropped write
        drive(1, 1, 2, 32'h1000_0040, 64'hCAFE_F00D);
        for (int j = 1; j <= 5; j++) idle();
        drive(1, 1, 2, 32'h1000_0044, 64'hDEAD_BEEF);
        chk("R3 dropped not forwarded", bus_valid, 0);
        drive(1, 0, 2, 32'h1000_0040, 0);
        chk("R3 latch unchanged", latch_rdata, 64'hCAFE_F00D);
        chk("R3 timing unchanged", 64'(stall_cycles), 64'(DRAIN + 1 - 7));
        idle();

        // R4 debug address exemption
        drive(1, 1, 2, 32'h1000_0050, 64'h1111_2222);
        for (int j = 1; j <= 5; j++) idle();
        drive(1, 1, 0, DBG, 64'h41);
        chk("R4 debug forwarded", bus_valid, 1);
        drive(1, 0, 2, 32'h1000_0050, 0);
        chk("R4 latch unchanged", latch_rdata, 64'h1111_2222);
        chk("R4 timing unchanged", 64'(stall_cycles), 64'(DRAIN + 1 - 7));
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule